// File: doc/BRIEF.md
# Downstream Command Mailbox

This block is a small register file through which host software sends one command at a time to an attached peripheral. Software first fills two header dwords and a data dword. It then writes header dword 0. If that write has its busy bit set, the command is launched. The block then presents the packed command to a link engine and holds it steady until the engine reports completion. Completion and error causes collect in a status register that software clears by writing ones.

The busy bit in header 0 is set by software and cleared by hardware. Software polls it to learn when the mailbox is free. For a get-config command, the dword the engine returns replaces header 1, and software reads it from there.

Top module: `dncmd_mailbox`

## Requirements
- R1: After reset, every register reads zero, `cmd_valid` is low and the busy bit (header 0 bit 3) reads 0.
- R2: The registers sit at these byte offsets: header 0 at 0x00, header 1 at 0x04, header 2 at 0x08, data at 0x0C and status at 0x70. Header 2 keeps only bits 7:0, and its bits 31:8 read zero. A read of any other offset returns zero.
- R3: A write to 0x00 with bit 3 set while idle stores the dword and launches it. From the next cycle `cmd_valid` is high, `cmd_hdr0` equals the written value with bit 3 set, and header 0 reads back with bit 3 = 1.
- R4: A write to 0x00 with bit 3 clear while idle stores bits 31:4 and 2:0 without launching. `cmd_valid` stays low.
- R5: A `cmd_done` pulse while busy ends the command. In the next cycle `cmd_valid` is low, bit 3 reads 0 and status bit 28 (complete) is set. Each set `done_err` bit sets one status bit: err[0]→bit 0 (bus error), err[1]→bit 1 (wait timeout), err[2]→bit 2 (CRC), err[3]→bit 4 (no response), err[4]→bit 5 (fatal), err[5]→bit 6 (non-fatal). A `cmd_done` pulse while idle has no effect.
- R6: When a command of type 1 (get-config, header 0 bits 2:0) completes, header 1 takes `done_rdata`. Completion of any other type leaves header 1 unchanged.
- R7: While busy, writes to 0x04, 0x08 and 0x0C are ignored. A write to 0x00 is dropped and sets status bit 6.
- R8: Writing to 0x70 clears each status bit written as one and leaves bits written as zero unchanged.
- R9: While `cmd_valid` is high, the four command outputs stay stable until the cycle after `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cmd_valid | output | 1 | Command pending toward the link engine |
| cmd_hdr0 | output | 32 | Header dword 0 |
| cmd_hdr1 | output | 32 | Header dword 1 |
| cmd_hdr2 | output | 32 | Header dword 2 |
| cmd_data | output | 32 | Data dword |
| cmd_done | input | 1 | Completion pulse from the link engine |
| done_err | input | 6 | Error causes reported with completion |
| done_rdata | input | 32 | Dword returned by the engine |

## Verification
A busy flag stuck high would show as a `cmd_valid` that never drops. It would also show as bit 3 still reading 1 one cycle after `cmd_done`. A wrong error mapping or a failed clear shows up on the first status read after completion or after a write-one-to-clear. A stored value that is corrupted or that accepts writes while busy shows up at once on the command outputs. It also shows up on the next readback of the header that was written.

// File: rtl/dncmd_mailbox.sv
module dncmd_mailbox #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          cmd_valid,
  output logic [31:0]   cmd_hdr0,
  output logic [31:0]   cmd_hdr1,
  output logic [31:0]   cmd_hdr2,
  output logic [31:0]   cmd_data,
  input  logic          cmd_done,
  input  logic [5:0]    done_err,
  input  logic [31:0]   done_rdata
);
  localparam logic [AW-1:0] OFS_H0  = AW'('h00);
  localparam logic [AW-1:0] OFS_H1  = AW'('h04);
  localparam logic [AW-1:0] OFS_H2  = AW'('h08);
  localparam logic [AW-1:0] OFS_DAT = AW'('h0C);
  localparam logic [AW-1:0] OFS_STS = AW'('h70);
  localparam int BUSY_BIT = 3;
  localparam int DONE_BIT = 28;
  localparam int NF_BIT   = 6;
  localparam logic [31:0] STS_MASK = 32'h1000_0077;
  localparam logic [2:0]  TYPE_GETCFG = 3'd1;

  logic        busy;
  logic [31:0] h0_q, h1_q, d_q, sts_q;
  logic [7:0]  h2_q;

  logic wr_h0, wr_h1, wr_h2, wr_dat, wr_sts, finish, launch, drop;
  logic [31:0] sts_set, sts_clr;

  assign wr_h0  = reg_wr && reg_addr == OFS_H0;
  assign wr_h1  = reg_wr && reg_addr == OFS_H1 && !busy;
  assign wr_h2  = reg_wr && reg_addr == OFS_H2 && !busy;
  assign wr_dat = reg_wr && reg_addr == OFS_DAT && !busy;
  assign wr_sts = reg_wr && reg_addr == OFS_STS;
  assign finish = busy && cmd_done;
  assign launch = wr_h0 && !busy && reg_wdata[BUSY_BIT];
  assign drop   = wr_h0 && busy;

  always_comb begin
    sts_set = '0;
    if (finish) begin
      sts_set[DONE_BIT] = 1'b1;
      sts_set[0] = done_err[0];
      sts_set[1] = done_err[1];
      sts_set[2] = done_err[2];
      sts_set[4] = done_err[3];
      sts_set[5] = done_err[4];
      sts_set[6] = done_err[5];
    end
    if (drop) sts_set[NF_BIT] = 1'b1;
  end

  assign sts_clr = wr_sts ? (reg_wdata & STS_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      h0_q  <= '0;
      h1_q  <= '0;
      h2_q  <= '0;
      d_q   <= '0;
      sts_q <= '0;
    end else begin
      if (wr_h0 && !busy) begin
        h0_q <= reg_wdata & ~(32'd1 << BUSY_BIT);
        busy <= reg_wdata[BUSY_BIT];
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (wr_h1) h1_q <= reg_wdata;
      else if (finish && h0_q[2:0] == TYPE_GETCFG) h1_q <= done_rdata;
      if (wr_h2)  h2_q <= reg_wdata[7:0];
      if (wr_dat) d_q  <= reg_wdata;
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  assign cmd_valid = busy;
  assign cmd_hdr0  = {h0_q[31:4], busy, h0_q[2:0]};
  assign cmd_hdr1  = h1_q;
  assign cmd_hdr2  = {24'd0, h2_q};
  assign cmd_data  = d_q;

  always_comb begin
    case (reg_addr)
      OFS_H0:  reg_rdata = cmd_hdr0;
      OFS_H1:  reg_rdata = h1_q;
      OFS_H2:  reg_rdata = {24'd0, h2_q};
      OFS_DAT: reg_rdata = d_q;
      OFS_STS: reg_rdata = sts_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_LAUNCH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_H0 && reg_wdata[BUSY_BIT] && !cmd_valid) |=> cmd_valid); // R3
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done) |=> (!cmd_valid && sts_q[DONE_BIT])); // R5
  AST_BUSY_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_H0 && cmd_valid) |=> sts_q[NF_BIT]); // R7
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> $stable({cmd_hdr0, cmd_hdr1, cmd_hdr2, cmd_data})); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STS && !(cmd_valid && cmd_done))
      |=> ((sts_q & $past(reg_wdata)) == 32'd0)); // R8
endmodule

// File: tb/dncmd_mailbox_test.sv
`timescale 1ns/1ps
module dncmd_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid;
  logic [31:0] cmd_hdr0, cmd_hdr1, cmd_hdr2, cmd_data;
  logic        cmd_done = 1'b0;
  logic [5:0]  done_err = '0;
  logic [31:0] done_rdata = '0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dncmd_mailbox #(.AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_hdr0(cmd_hdr0), .cmd_hdr1(cmd_hdr1), .cmd_hdr2(cmd_hdr2),
    .cmd_data(cmd_data), .cmd_done(cmd_done), .done_err(done_err),
    .done_rdata(done_rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic done_pulse(input logic [5:0] e, input logic [31:0] r);
    @(negedge clk);
    cmd_done = 1'b1; done_err = e; done_rdata = r;
    @(negedge clk);
    cmd_done = 1'b0; done_err = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 hdr0", v, 0);
    rd(8'h04, v); check("R1 hdr1", v, 0);
    rd(8'h08, v); check("R1 hdr2", v, 0);
    rd(8'h0C, v); check("R1 data", v, 0);
    rd(8'h70, v); check("R1 status", v, 0);
    check("R1 valid", {31'd0, cmd_valid}, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(8'h04, 32'hAABBCCDD);
    wr(8'h08, 32'hFFFFFF5A);
    wr(8'h0C, 32'h11223344);
    rd(8'h04, v); check("R2 hdr1", v, 32'hAABBCCDD);
    rd(8'h08, v); check("R2 hdr2 low byte only", v, 32'h0000005A);
    rd(8'h0C, v); check("R2 data", v, 32'h11223344);
    rd(8'h10, v); check("R2 unmapped", v, 0);
  endtask

  task automatic t_store_only;
    logic [31:0] v;
    wr(8'h00, 32'h00341200);
    rd(8'h00, v); check("R4 stored", v, 32'h00341200);
    check("R4 no launch", {31'd0, cmd_valid}, 0);
  endtask

  task automatic t_setcfg_busy;
    logic [31:0] v;
    wr(8'h00, 32'h00201008);
    check("R3 valid", {31'd0, cmd_valid}, 1);
    check("R3 cmd_hdr0", cmd_hdr0, 32'h00201008);
    rd(8'h00, v); check("R3 busy readback", v, 32'h00201008);
    wr(8'h04, 32'h12345678);
    rd(8'h04, v); check("R7 hdr1 ignored", v, 32'hAABBCCDD);
    wr(8'h0C, 32'h0);
    check("R7 data ignored", cmd_data, 32'h11223344);
    wr(8'h00, 32'h000000FF);
    check("R9 hdr0 stable", cmd_hdr0, 32'h00201008);
    rd(8'h70, v); check("R7 drop flag", v, 32'h00000040);
    done_pulse(6'd0, 32'hCAFEF00D);
    check("R5 valid low", {31'd0, cmd_valid}, 0);
    rd(8'h00, v); check("R5 busy cleared", v, 32'h00201000);
    rd(8'h70, v); check("R5 complete", v, 32'h10000040);
    rd(8'h04, v); check("R6 hdr1 kept", v, 32'hAABBCCDD);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(8'h70, 32'h00000040);
    rd(8'h70, v); check("R8 partial clear", v, 32'h10000000);
    wr(8'h70, 32'h0);
    rd(8'h70, v); check("R8 zero no effect", v, 32'h10000000);
    wr(8'h70, 32'h10000000);
    rd(8'h70, v); check("R8 full clear", v, 0);
  endtask

  task automatic t_getcfg;
    logic [31:0] v;
    wr(8'h00, 32'h00001009);
    check("R3 getcfg valid", {31'd0, cmd_valid}, 1);
    done_pulse(6'b101011, 32'hDEADBEEF);
    rd(8'h04, v); check("R6 returned dword", v, 32'hDEADBEEF);
    rd(8'h70, v); check("R5 error mapping", v, 32'h10000053);
    wr(8'h70, 32'hFFFFFFFF);
    done_pulse(6'b111111, 32'h0);
    rd(8'h70, v); check("R5 idle done ignored", v, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_store_only();
    t_setcfg_busy();
    t_w1c();
    t_getcfg();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule